// File: doc/BRIEF.md
# Multibank DRAM Command Legality Checker

This block sits beside the command bus of a multibank graphics DDR SDRAM and checks each command as it goes by. For every bank it keeps the kind of action that bank is busy with and how many cycles that action still has to run. It also keeps short shared windows that count from the latest activate, write and read command on any bank. A new command is tested against the actions still running on the *other* banks. If the overlap is not permitted, the block raises a violation flag and a reason code on the next clock.

Commands arrive as a 3-bit code, a bank index and a valid strobe. All timing values and the burst length are parameters in clock cycles. The block is a passive monitor. It never stalls the bus, and every valid command updates the tracked state, whether the command was legal or not. A designer places it next to a memory controller in simulation or in silicon to catch scheduling mistakes at the cycle where they happen.

Top module: `dramCmdGuard`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives `violation` to 0 and `reason` to 0. It closes every bank, ends every per-bank action and expires every shared window.
- R2: Command codes are 0 NOP, 1 ACT, 2 PRE, 3 PRE-ALL, 4 WR, 5 WR/A, 6 RD, 7 RD/A. `violation` and `reason` give the verdict on the command sampled at the previous rising edge. A cycle with `cmdValid` low, or with code NOP, is never flagged and changes no tracked state.
- R3: PRE-ALL keeps a global window busy for commands issued 1 to T_RP-1 cycles after it. Any non-NOP command in that window gets reason 1.
- R4: ACT to a bank that is already open gets reason 2. ACT opens a bank. PRE, PRE-ALL (all banks), WR/A and RD/A close it when they are issued.
- R5: An activate action runs for commands 1 to T_RCD-1 cycles after the ACT. An ACT issued while another bank is activating, and fewer than T_RRD cycles after the latest ACT, gets reason 3.
- R6: A write action (WR or WR/A) runs for commands 1 to BURST_LEN+T_WR-1 cycles after it. RD/A issued while another bank runs a WR/A action gets reason 4.
- R7: RD or RD/A issued while another bank runs a write action, and fewer than T_WTR cycles after the latest write command, gets reason 5.
- R8: WR or WR/A issued while another bank runs a write action, with a write command in the immediately preceding cycle, gets reason 6.
- R9: A read action runs for commands 1 to READ_LAT+BURST_LEN-1 cycles after it. RD or RD/A issued while another bank runs a read action, with a read command in the immediately preceding cycle, gets reason 7.
- R10: WR or WR/A issued while another bank runs a read action, and fewer than T_RTW cycles after the latest read command, gets reason 8.
- R11: An action only restricts commands to other banks. A command to the same bank as a running action is not flagged by R5 to R10. ACT and PRE to another bank are legal during write and read actions.
- R12: When several rules fail, the reported reason is the first that applies in the order 1, 2, 3, 4, 5, 6, 7, 8. `violation` is 1 exactly when `reason` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | The command fields are valid this cycle |
| cmdCode | input | 3 | Command code (see R2) |
| cmdBank | input | $clog2(N_BANKS) | Bank the command addresses |
| violation | output | 1 | Previous command overlapped illegally |
| reason | output | 4 | Rule that failed, 0 when legal |

## Verification
Each overlap rule is driven twice. The second command is placed once inside the window and once at the first cycle where the window has expired, so an off-by-one in any counter load shows up as a wrong verdict. Write, read and activate pairs are also sent to the same bank and then to a different bank. This separates rules that are correctly limited to other banks from rules that fire on any bank. An invalid ACT followed by a legal ACT shows whether a masked command leaked into the activate-to-activate window. An auto-precharge read followed by an ACT to the same bank shows whether the bank was closed. Overlapping rule failures check the reported priority.

// File: rtl/dramCmdGuardPkg.sv
package dramCmdGuardPkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_WR   = 3'd4,
    CMD_WRA  = 3'd5,
    CMD_RD   = 3'd6,
    CMD_RDA  = 3'd7
  } dramCmd_e;

  typedef enum logic [3:0] {
    RSN_NONE        = 4'd0,
    RSN_PREALL_BUSY = 4'd1,
    RSN_ACT_OPEN    = 4'd2,
    RSN_RRD         = 4'd3,
    RSN_RDA_WRA     = 4'd4,
    RSN_WTR         = 4'd5,
    RSN_WR_GAP      = 4'd6,
    RSN_RD_GAP      = 4'd7,
    RSN_RTW         = 4'd8
  } reason_e;

  typedef enum logic [2:0] {
    ACTN_IDLE = 3'd0,
    ACTN_ACT  = 3'd1,
    ACTN_WR   = 3'd2,
    ACTN_WRA  = 3'd3,
    ACTN_RD   = 3'd4,
    ACTN_RDA  = 3'd5,
    ACTN_PRE  = 3'd6
  } bankAction_e;

  // Strobes from control to datapath, one per command class
  typedef struct packed {
    logic act;
    logic pre;
    logic preAll;
    logic wr;
    logic rd;
    logic autoPre;
  } trackStrobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/winTimer.sv
// Down-counting window: busy for LOAD cycles after a start pulse
module winTimer #(
  parameter int CNT_W = 4,
  parameter int LOAD  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (start) begin
      cntQ <= LOAD_V;
    end else if (cntQ != '0) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign busy = (cntQ != '0);
endmodule

// File: rtl/cmdBankTracker.sv
// Datapath: per-bank action tracking plus shared command windows
module cmdBankTracker
  import dramCmdGuardPkg::*;
#(
  parameter int N_BANKS   = 8,
  parameter int BANK_W    = 3,
  parameter int CNT_W     = 4,
  parameter int ACT_DUR   = 5,
  parameter int WR_DUR    = 8,
  parameter int RD_DUR    = 10,
  parameter int PRE_DUR   = 5,
  parameter int RRD_WIN   = 3,
  parameter int WTR_WIN   = 6,
  parameter int RTW_WIN   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  trackStrobe_t       strobe,
  input  logic [BANK_W-1:0]  bankSel,
  output logic [N_BANKS-1:0] actBusy,
  output logic [N_BANKS-1:0] wrBusy,
  output logic [N_BANKS-1:0] wraBusy,
  output logic [N_BANKS-1:0] rdBusy,
  output logic [N_BANKS-1:0] bankOpen,
  output logic               preAllBusy,
  output logic               rrdBusy,
  output logic               wtrBusy,
  output logic               rtwBusy,
  output logic               prevWrite,
  output logic               prevRead
);
  localparam logic [CNT_W-1:0] ACT_LD = CNT_W'(ACT_DUR - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_DUR - 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_DUR - 1);
  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_DUR - 1);

  bankAction_e      nextKind;
  logic [CNT_W-1:0] nextLoad;
  logic             bankCmd;

  assign bankCmd = strobe.act | strobe.pre | strobe.wr | strobe.rd;

  always_comb begin
    nextKind = ACTN_IDLE;
    nextLoad = '0;
    if (strobe.act) begin
      nextKind = ACTN_ACT;
      nextLoad = ACT_LD;
    end else if (strobe.pre) begin
      nextKind = ACTN_PRE;
      nextLoad = PRE_LD;
    end else if (strobe.wr) begin
      nextKind = strobe.autoPre ? ACTN_WRA : ACTN_WR;
      nextLoad = WR_LD;
    end else if (strobe.rd) begin
      nextKind = strobe.autoPre ? ACTN_RDA : ACTN_RD;
      nextLoad = RD_LD;
    end
  end

  for (genvar g = 0; g < N_BANKS; g++) begin : gBank
    bankAction_e      kindQ;
    logic [CNT_W-1:0] cntQ;
    logic             openQ;
    logic             hit;
    logic             running;

    assign hit     = (bankSel == BANK_W'(g));
    assign running = (cntQ != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        kindQ <= ACTN_IDLE;
        cntQ  <= '0;
        openQ <= 1'b0;
      end else begin
        if (hit && bankCmd) begin
          kindQ <= nextKind;
          cntQ  <= nextLoad;
        end else if (running) begin
          cntQ <= cntQ - CNT_W'(1);
        end

        if (strobe.preAll) begin
          openQ <= 1'b0;
        end else if (hit && strobe.act) begin
          openQ <= 1'b1;
        end else if (hit && (strobe.pre || ((strobe.wr || strobe.rd) && strobe.autoPre))) begin
          openQ <= 1'b0;
        end
      end
    end

    assign actBusy[g]  = running && (kindQ == ACTN_ACT);
    assign wrBusy[g]   = running && ((kindQ == ACTN_WR) || (kindQ == ACTN_WRA));
    assign wraBusy[g]  = running && (kindQ == ACTN_WRA);
    assign rdBusy[g]   = running && ((kindQ == ACTN_RD) || (kindQ == ACTN_RDA));
    assign bankOpen[g] = openQ;
  end

  winTimer #(.CNT_W(CNT_W), .LOAD(PRE_DUR - 1)) preAllTimer_i (
    .clk(clk), .rst(rst), .start(strobe.preAll), .busy(preAllBusy));

  winTimer #(.CNT_W(CNT_W), .LOAD(RRD_WIN - 1)) rrdTimer_i (
    .clk(clk), .rst(rst), .start(strobe.act), .busy(rrdBusy));

  winTimer #(.CNT_W(CNT_W), .LOAD(WTR_WIN - 1)) wtrTimer_i (
    .clk(clk), .rst(rst), .start(strobe.wr), .busy(wtrBusy));

  winTimer #(.CNT_W(CNT_W), .LOAD(RTW_WIN - 1)) rtwTimer_i (
    .clk(clk), .rst(rst), .start(strobe.rd), .busy(rtwBusy));

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWrite <= 1'b0;
      prevRead  <= 1'b0;
    end else begin
      prevWrite <= strobe.wr;
      prevRead  <= strobe.rd;
    end
  end
endmodule

// File: rtl/cmdRuleCtrl.sv
// Control: decodes commands, evaluates overlap rules, registers verdict
module cmdRuleCtrl
  import dramCmdGuardPkg::*;
#(
  parameter int N_BANKS = 8,
  parameter int BANK_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  input  logic [2:0]         cmdCode,
  input  logic [BANK_W-1:0]  cmdBank,
  input  logic [N_BANKS-1:0] actBusy,
  input  logic [N_BANKS-1:0] wrBusy,
  input  logic [N_BANKS-1:0] wraBusy,
  input  logic [N_BANKS-1:0] rdBusy,
  input  logic [N_BANKS-1:0] bankOpen,
  input  logic               preAllBusy,
  input  logic               rrdBusy,
  input  logic               wtrBusy,
  input  logic               rtwBusy,
  input  logic               prevWrite,
  input  logic               prevRead,
  output trackStrobe_t       strobe,
  output logic [BANK_W-1:0]  bankSel,
  output logic               violation,
  output logic [3:0]         reason
);
  dramCmd_e           cmdE;
  logic               isAct, isPre, isPreA, isWr, isWra, isRd, isRda;
  logic               anyCmd, anyWrite, anyRead;
  logic [N_BANKS-1:0] ownMask;
  logic               ownOpen, otherAct, otherWr, otherWra, otherRd;
  reason_e            rsnNext;

  assign cmdE    = dramCmd_e'(cmdCode);
  assign isAct   = cmdValid && (cmdE == CMD_ACT);
  assign isPre   = cmdValid && (cmdE == CMD_PRE);
  assign isPreA  = cmdValid && (cmdE == CMD_PREA);
  assign isWr    = cmdValid && (cmdE == CMD_WR);
  assign isWra   = cmdValid && (cmdE == CMD_WRA);
  assign isRd    = cmdValid && (cmdE == CMD_RD);
  assign isRda   = cmdValid && (cmdE == CMD_RDA);
  assign anyCmd  = cmdValid && (cmdE != CMD_NOP);
  assign anyWrite = isWr | isWra;
  assign anyRead  = isRd | isRda;

  for (genvar g = 0; g < N_BANKS; g++) begin : gOwn
    assign ownMask[g] = (cmdBank == BANK_W'(g));
  end

  assign ownOpen  = |(bankOpen & ownMask);
  assign otherAct = |(actBusy & ~ownMask);
  assign otherWr  = |(wrBusy & ~ownMask);
  assign otherWra = |(wraBusy & ~ownMask);
  assign otherRd  = |(rdBusy & ~ownMask);

  always_comb begin
    strobe.act     = isAct;
    strobe.pre     = isPre;
    strobe.preAll  = isPreA;
    strobe.wr      = anyWrite;
    strobe.rd      = anyRead;
    strobe.autoPre = isWra | isRda;
  end

  assign bankSel = cmdBank;

  // Ordered rule chain: earlier checks win
  always_comb begin
    rsnNext = RSN_NONE;
    if (anyCmd && preAllBusy) begin
      rsnNext = RSN_PREALL_BUSY;
    end else if (isAct && ownOpen) begin
      rsnNext = RSN_ACT_OPEN;
    end else if (isAct && otherAct && rrdBusy) begin
      rsnNext = RSN_RRD;
    end else if (isRda && otherWra) begin
      rsnNext = RSN_RDA_WRA;
    end else if (anyRead && otherWr && wtrBusy) begin
      rsnNext = RSN_WTR;
    end else if (anyWrite && otherWr && prevWrite) begin
      rsnNext = RSN_WR_GAP;
    end else if (anyRead && otherRd && prevRead) begin
      rsnNext = RSN_RD_GAP;
    end else if (anyWrite && otherRd && rtwBusy) begin
      rsnNext = RSN_RTW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      violation <= 1'b0;
      reason    <= 4'd0;
    end else begin
      violation <= (rsnNext != RSN_NONE);
      reason    <= rsnNext;
    end
  end
endmodule

// File: rtl/dramCmdGuard.sv
module dramCmdGuard
  import dramCmdGuardPkg::*;
#(
  parameter int N_BANKS   = 8,
  parameter int T_RCD     = 5,
  parameter int T_RRD     = 3,
  parameter int T_WR      = 4,
  parameter int BURST_LEN = 4,
  parameter int READ_LAT  = 6,
  parameter int T_RP      = 5,
  parameter int T_WTR     = 6,
  parameter int T_RTW     = 4,
  localparam int BANK_W   = $clog2(N_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  output logic              violation,
  output logic [3:0]        reason
);
  localparam int WR_DUR  = BURST_LEN + T_WR;
  localparam int RD_DUR  = READ_LAT + BURST_LEN;
  localparam int MAX_DUR = maxInt(maxInt(maxInt(T_RCD, WR_DUR), maxInt(RD_DUR, T_RP)),
                                  maxInt(maxInt(T_RRD, T_WTR), T_RTW));
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  trackStrobe_t       strobe;
  logic [BANK_W-1:0]  bankSel;
  logic [N_BANKS-1:0] actBusy, wrBusy, wraBusy, rdBusy, bankOpen;
  logic               preAllBusy, rrdBusy, wtrBusy, rtwBusy, prevWrite, prevRead;

  cmdRuleCtrl #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .actBusy(actBusy), .wrBusy(wrBusy), .wraBusy(wraBusy), .rdBusy(rdBusy),
    .bankOpen(bankOpen), .preAllBusy(preAllBusy), .rrdBusy(rrdBusy),
    .wtrBusy(wtrBusy), .rtwBusy(rtwBusy), .prevWrite(prevWrite), .prevRead(prevRead),
    .strobe(strobe), .bankSel(bankSel), .violation(violation), .reason(reason));

  cmdBankTracker #(
    .N_BANKS(N_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .ACT_DUR(T_RCD), .WR_DUR(WR_DUR), .RD_DUR(RD_DUR), .PRE_DUR(T_RP),
    .RRD_WIN(T_RRD), .WTR_WIN(T_WTR), .RTW_WIN(T_RTW)
  ) track_i (
    .clk(clk), .rst(rst), .strobe(strobe), .bankSel(bankSel),
    .actBusy(actBusy), .wrBusy(wrBusy), .wraBusy(wraBusy), .rdBusy(rdBusy),
    .bankOpen(bankOpen), .preAllBusy(preAllBusy), .rrdBusy(rrdBusy),
    .wtrBusy(wtrBusy), .rtwBusy(rtwBusy), .prevWrite(prevWrite), .prevRead(prevRead));
endmodule

// File: rtl/dramCmdGuardSva.sv
module dramCmdGuardSva #(
  parameter int BANK_W = 3,
  parameter int T_RCD  = 5,
  parameter int T_RRD  = 3,
  parameter int T_RP   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic [2:0]        cmdCode,
  input logic [BANK_W-1:0] cmdBank,
  input logic              violation,
  input logic [3:0]        reason
);
  // R1: the cycle after reset shows a clean verdict
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!violation && reason == 4'd0));

  // R2: masked or NOP cycles are never flagged
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!cmdValid || cmdCode == 3'd0) |=> !violation);

  // R12: flag and code agree
  p_flag_code_r12: assert property (@(posedge clk) disable iff (rst)
    violation |-> (reason != 4'd0 && reason <= 4'd8));

  // R8: back-to-back writes to different banks
  p_wr_gap_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdValid && cmdCode[2:1] == 2'b10) && cmdValid && cmdCode[2:1] == 2'b10 &&
     cmdBank != $past(cmdBank)) |=> violation);

  // R9: back-to-back reads to different banks
  p_rd_gap_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdValid && cmdCode[2:1] == 2'b11) && cmdValid && cmdCode[2:1] == 2'b11 &&
     cmdBank != $past(cmdBank)) |=> violation);

  if (T_RRD > 1 && T_RCD > 1) begin : gRrd
    // R5: back-to-back activates to different banks
    p_act_pair_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(cmdValid && cmdCode == 3'd1) && cmdValid && cmdCode == 3'd1 &&
       cmdBank != $past(cmdBank)) |=> violation);
  end

  if (T_RP > 1) begin : gPreAll
    // R3: a command right after precharge-all
    p_preall_busy_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(cmdValid && cmdCode == 3'd3) && cmdValid && cmdCode != 3'd0) |=> violation);
  end
endmodule

bind dramCmdGuard dramCmdGuardSva #(
  .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP)
) sva_i (
  .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .cmdBank(cmdBank), .violation(violation), .reason(reason));

// File: tb/dramCmdGuard_tb_top.sv
module dramCmdGuard_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_PREA = 3'd3,
                         C_WR = 3'd4, C_WRA = 3'd5, C_RD = 3'd6, C_RDA = 3'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [2:0] cmdBank = 3'd0;
  logic       violation;
  logic [3:0] reason;

  int compared = 0;
  int mismatched = 0;

  dramCmdGuard dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .violation(violation), .reason(reason));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkOut(input int expRsn, input string tag);
    compared++;
    if (violation !== (expRsn != 0) || reason !== 4'(expRsn)) begin
      mismatched++;
      $display("FAIL %s: violation=%0b reason=%0d expected violation=%0b reason=%0d",
               tag, violation, reason, (expRsn != 0), expRsn);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one command, check the verdict one cycle later
  task automatic step(input logic vld, input logic [2:0] code, input logic [2:0] bank,
                      input int expRsn, input string tag);
    cmdValid = vld;
    cmdCode  = code;
    cmdBank  = bank;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdCode  = C_NOP;
    checkOut(expRsn, tag);
  endtask

  task automatic testReset();
    doReset();
    checkOut(0, "R1 reset outputs");
    step(1, C_ACT, 3'd0, 0, "R1 act before reset");
    doReset();
    checkOut(0, "R1 outputs after second reset");
    step(1, C_ACT, 3'd0, 0, "R1 bank closed by reset");
  endtask

  task automatic testRrd();
    doReset();
    step(1, C_ACT, 3'd0, 0, "R5 first act");
    step(1, C_ACT, 3'd1, 3, "R5 act one cycle later");
    doReset();
    step(1, C_ACT, 3'd0, 0, "R5 first act");
    idle(2);
    step(1, C_ACT, 3'd1, 0, "R5 act after rrd");
  endtask

  task automatic testActOpen();
    doReset();
    step(1, C_ACT, 3'd0, 0, "R4 open bank");
    idle(5);
    step(1, C_ACT, 3'd0, 2, "R4 act to open bank");
    step(1, C_PRE, 3'd0, 0, "R4 close bank");
    step(1, C_ACT, 3'd0, 0, "R4 reopen after pre");
  endtask

  task automatic testAutoPreClose();
    doReset();
    step(1, C_ACT, 3'd0, 0, "R4 open bank");
    idle(5);
    step(1, C_RDA, 3'd0, 0, "R4 read with auto precharge");
    step(1, C_ACT, 3'd0, 0, "R4 act after auto precharge");
  endtask

  task automatic testActAllowed();
    doReset();
    step(1, C_ACT, 3'd0, 0, "R11 act");
    step(1, C_PRE, 3'd1, 0, "R11 pre during activate");
    step(1, C_WR, 3'd2, 0, "R11 write during activate");
    doReset();
    step(1, C_WR, 3'd0, 0, "R11 write");
    step(1, C_ACT, 3'd1, 0, "R11 act during write");
    step(1, C_PRE, 3'd2, 0, "R11 pre during write");
  endtask

  task automatic testWrGap();
    doReset();
    step(1, C_WR, 3'd0, 0, "R8 first write");
    step(1, C_WRA, 3'd1, 6, "R8 back-to-back write");
    doReset();
    step(1, C_WR, 3'd0, 0, "R8 first write");
    idle(1);
    step(1, C_WR, 3'd1, 0, "R8 write after one nop");
    doReset();
    step(1, C_WR, 3'd0, 0, "R11 write");
    step(1, C_WR, 3'd0, 0, "R11 same-bank write");
  endtask

  task automatic testWtr();
    doReset();
    step(1, C_WR, 3'd0, 0, "R7 write");
    idle(2);
    step(1, C_RD, 3'd1, 5, "R7 read inside wtr");
    doReset();
    step(1, C_WR, 3'd0, 0, "R7 write");
    idle(5);
    step(1, C_RD, 3'd1, 0, "R7 read after wtr");
  endtask

  task automatic testRdaWra();
    doReset();
    step(1, C_WRA, 3'd0, 0, "R6 write auto");
    idle(6);
    step(1, C_RDA, 3'd1, 4, "R6 read auto during write auto");
    doReset();
    step(1, C_WRA, 3'd0, 0, "R6 write auto");
    idle(6);
    step(1, C_RD, 3'd1, 0, "R6 plain read allowed");
    doReset();
    step(1, C_WRA, 3'd0, 0, "R12 write auto");
    idle(1);
    step(1, C_RDA, 3'd1, 4, "R12 rda beats wtr");
  endtask

  task automatic testRdGap();
    doReset();
    step(1, C_RD, 3'd0, 0, "R9 first read");
    step(1, C_RDA, 3'd1, 7, "R9 back-to-back read");
    doReset();
    step(1, C_RD, 3'd0, 0, "R9 first read");
    idle(1);
    step(1, C_RD, 3'd1, 0, "R9 read after one nop");
  endtask

  task automatic testRtw();
    doReset();
    step(1, C_RD, 3'd0, 0, "R10 read");
    idle(1);
    step(1, C_WR, 3'd1, 8, "R10 write inside rtw");
    doReset();
    step(1, C_RD, 3'd0, 0, "R10 read");
    idle(3);
    step(1, C_WR, 3'd1, 0, "R10 write after rtw");
  endtask

  task automatic testPreAll();
    doReset();
    step(1, C_PREA, 3'd0, 0, "R3 precharge all");
    idle(1);
    step(1, C_ACT, 3'd3, 1, "R3 act during precharge all");
    doReset();
    step(1, C_PREA, 3'd0, 0, "R3 precharge all");
    idle(4);
    step(1, C_ACT, 3'd3, 0, "R3 act after precharge all");
  endtask

  task automatic testInvalid();
    doReset();
    step(1, C_ACT, 3'd0, 0, "R2 act");
    step(0, C_ACT, 3'd2, 0, "R2 masked act");
    idle(1);
    step(1, C_ACT, 3'd1, 0, "R2 masked act left no window");
    step(1, C_NOP, 3'd1, 0, "R2 nop");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    testReset();
    testRrd();
    testActOpen();
    testAutoPreClose();
    testActAllowed();
    testWrGap();
    testWtr();
    testRdaWra();
    testRdGap();
    testRtw();
    testPreAll();
    testInvalid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule